// File: doc/BRIEF.md
# Binary32 NaN Classifier and Quieter

This block sits at the operand intake of a floating-point unit. It takes one 32-bit IEEE-754 single-precision word and reports whether the word is a quiet NaN, a signaling NaN, or not a NaN at all. It also returns a quieted copy of the word, which is the value a later NaN-propagation stage would forward. Arithmetic, rounding and exception flag accumulation stay outside; the block only classifies and silences.

Three elaboration-time choices adapt it to different floating-point conventions. `QUIET_WHEN_SET` selects the meaning of the top fraction bit (bit 22): set means quiet, or set means signaling. `SIGNAL_EN` can remove signaling NaNs altogether, so that every NaN is treated as quiet. `PIPE_EN` inserts one register stage with a valid flag travelling beside the data; without it the block is purely combinational and the valid flag passes straight through. Under the inverted convention a signaling NaN cannot be silenced by setting a bit, so it is replaced by the parameter `DEFAULT_NAN`, which defaults to 0x7FBFFFFF.

Top module: `nanq_unit`

## Requirements
- R1: With `QUIET_WHEN_SET`=1 and `SIGNAL_EN`=1, a word whose exponent field (bits 30..23) is all ones and whose bit 22 is 1 is reported quiet (`out_quiet`=1), whatever its sign bit 31.
- R2: With `QUIET_WHEN_SET`=1 and `SIGNAL_EN`=1, a word whose exponent field is all ones, whose bit 22 is 0 and whose bits 21..0 are nonzero is reported signaling (`out_signal`=1).
- R3: Infinities (exponent all ones, fraction zero), zeros, subnormals and ordinary numbers give `out_quiet`=`out_signal`=`out_nan`=0 and leave `out_word` equal to the input word in every configuration.
- R4: With `QUIET_WHEN_SET`=1, a signaling NaN is quieted by setting bit 22 and keeping every other bit; a quiet NaN passes through unchanged.
- R5: With `QUIET_WHEN_SET`=0 and `SIGNAL_EN`=1, the tests swap: exponent all ones with bit 22 equal to 1 is signaling, and exponent all ones with bit 22 equal to 0 and bits 21..0 nonzero is quiet.
- R6: With `QUIET_WHEN_SET`=0, a signaling NaN is replaced on `out_word` by `DEFAULT_NAN` (0x7FBFFFFF by default); quiet NaNs pass through unchanged.
- R7: With `SIGNAL_EN`=0, every NaN (exponent all ones, fraction nonzero) is reported quiet, `out_signal` stays 0 and `out_word` equals the input.
- R8: `out_nan` is 1 exactly when `out_quiet` or `out_signal` is 1, and `out_quiet` and `out_signal` are never 1 together.
- R9: With `PIPE_EN`=1, the results for a word presented with `in_valid`=1 appear on the outputs after the next rising clock edge, `out_valid` equals `in_valid` delayed by one cycle, and the data outputs hold their value after a cycle with `in_valid`=0. With `PIPE_EN`=0, outputs follow the input in the same cycle and `out_valid` equals `in_valid`.
- R10: While `rst_n` is 0, `out_valid` is 0 and, with `PIPE_EN`=1, the registered data outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_word | input | 32 | Binary32 operand |
| out_valid | output | 1 | Results are valid |
| out_quiet | output | 1 | Operand is a quiet NaN |
| out_signal | output | 1 | Operand is a signaling NaN |
| out_nan | output | 1 | Operand is any NaN |
| out_word | output | 32 | Operand with a signaling NaN silenced |

## Verification
The bench builds three copies side by side: normal polarity with signaling support and the register stage, inverted polarity with the register stage, and signaling disabled with no register stage. The same operand table runs through all three at once, so every corner word (signed infinities and zeros, smallest signaling and quiet payloads, the all-ones fraction) is seen under both meanings of bit 22 and with signaling removed. The registered copies bring the one-cycle latency, the hold after an idle cycle and the asynchronous reset within reach, while the combinational copy shows same-cycle behaviour of the valid flag.

// File: rtl/nanq_pkg.sv
package nanq_pkg;

  localparam int WORD_W = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = WORD_W - EXP_W - 1;
  localparam int QBIT   = FRAC_W - 1;
  localparam int EXP_HI = WORD_W - 2;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic quiet;
    logic signal;
    logic any;
  } nan_class_t;

  localparam int CLASS_W = $bits(nan_class_t);

  function automatic logic exp_saturated(word_t w);
    return &w[EXP_HI -: EXP_W];
  endfunction

  function automatic logic tail_nonzero(word_t w);
    return |w[QBIT-1:0];
  endfunction

  // Classify one word. top_hit: exponent saturated and bit QBIT set;
  // low_hit: exponent saturated, bit QBIT clear, rest of fraction nonzero.
  function automatic nan_class_t classify(word_t w, logic normal_pol, logic sig_en);
    nan_class_t c;
    logic top_hit;
    logic low_hit;
    top_hit  = exp_saturated(w) & w[QBIT];
    low_hit  = exp_saturated(w) & ~w[QBIT] & tail_nonzero(w);
    c.any    = exp_saturated(w) & (w[QBIT] | tail_nonzero(w));
    if (!sig_en) begin
      c.quiet  = c.any;
      c.signal = 1'b0;
    end else if (normal_pol) begin
      c.quiet  = top_hit;
      c.signal = low_hit;
    end else begin
      c.quiet  = low_hit;
      c.signal = top_hit;
    end
    return c;
  endfunction

  function automatic word_t quieten(word_t w, logic is_signal, logic normal_pol,
                                    word_t dflt);
    word_t r;
    r = w;
    if (is_signal) begin
      if (normal_pol) r[QBIT] = 1'b1;
      else            r = dflt;
    end
    return r;
  endfunction

endpackage

// File: rtl/nanq_classify.sv
module nanq_classify
  import nanq_pkg::*;
#(
  parameter bit NORMAL_POL = 1'b1,
  parameter bit SIGNAL_EN  = 1'b1
) (
  input  word_t      word_i,
  output nan_class_t cls_o
);

  assign cls_o = classify(word_i, NORMAL_POL, SIGNAL_EN);

endmodule

// File: rtl/nanq_silence.sv
module nanq_silence
  import nanq_pkg::*;
#(
  parameter bit    NORMAL_POL  = 1'b1,
  parameter word_t DEFAULT_NAN = 32'h7FBF_FFFF
) (
  input  word_t word_i,
  input  logic  signal_i,
  output word_t word_o
);

  assign word_o = quieten(word_i, signal_i, NORMAL_POL, DEFAULT_NAN);

endmodule

// File: rtl/nanq_pipe.sv
module nanq_pipe #(
  parameter bit PIPE_EN = 1'b1,
  parameter int DATA_W  = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o
);

  generate
    if (PIPE_EN) begin : g_reg
      logic              vld_q;
      logic [DATA_W-1:0] data_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          data_q <= '0;
        end else begin
          vld_q <= vld_i;
          if (vld_i) data_q <= data_i;
        end
      end
      assign vld_o  = vld_q;
      assign data_o = data_q;
    end else begin : g_wire
      assign vld_o  = vld_i;
      assign data_o = data_i;
    end
  endgenerate

endmodule

// File: rtl/nanq_unit.sv
module nanq_unit
  import nanq_pkg::*;
#(
  parameter bit    QUIET_WHEN_SET = 1'b1,
  parameter bit    SIGNAL_EN      = 1'b1,
  parameter bit    PIPE_EN        = 1'b1,
  parameter word_t DEFAULT_NAN    = 32'h7FBF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic              out_quiet,
  output logic              out_signal,
  output logic              out_nan,
  output logic [WORD_W-1:0] out_word
);

  localparam int STAGE_W = CLASS_W + WORD_W;

  // Named internal events, visible to the assertions below.
  nan_class_t           det_cls;
  word_t                fix_word;
  logic [STAGE_W-1:0]   stage_in;
  logic [STAGE_W-1:0]   stage_out;
  nan_class_t           res_cls;

  nanq_classify #(
    .NORMAL_POL (QUIET_WHEN_SET),
    .SIGNAL_EN  (SIGNAL_EN)
  ) u_classify (
    .word_i (in_word),
    .cls_o  (det_cls)
  );

  nanq_silence #(
    .NORMAL_POL  (QUIET_WHEN_SET),
    .DEFAULT_NAN (DEFAULT_NAN)
  ) u_silence (
    .word_i   (in_word),
    .signal_i (det_cls.signal),
    .word_o   (fix_word)
  );

  assign stage_in = {det_cls, fix_word};

  nanq_pipe #(
    .PIPE_EN (PIPE_EN),
    .DATA_W  (STAGE_W)
  ) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (in_valid),
    .data_i (stage_in),
    .vld_o  (out_valid),
    .data_o (stage_out)
  );

  assign res_cls    = stage_out[STAGE_W-1 -: CLASS_W];
  assign out_word   = stage_out[WORD_W-1:0];
  assign out_quiet  = res_cls.quiet;
  assign out_signal = res_cls.signal;
  assign out_nan    = res_cls.any;

  // ---------------- assertions ----------------
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_quiet, out_signal}))
    else $error("quiet and signaling both high");

  a_r8_nan_union: assert property (@(posedge clk) disable iff (!rst_n)
    out_nan == (out_quiet | out_signal))
    else $error("any-NaN flag disagrees with class flags");

  a_r3_nonnan_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_nan) |-> (out_word == $past(in_word) || !PIPE_EN))
    else $error("non-NaN word altered");

  generate
    if (!SIGNAL_EN) begin : g_chk_nosig
      a_r7_no_signal: assert property (@(posedge clk) disable iff (!rst_n)
        !out_signal)
        else $error("signaling reported while disabled");
    end else if (QUIET_WHEN_SET) begin : g_chk_norm
      a_r4_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        out_signal |-> out_word[QBIT])
        else $error("signaling NaN left without quiet bit");
    end else begin : g_chk_inv
      a_r6_default: assert property (@(posedge clk) disable iff (!rst_n)
        out_signal |-> out_word == DEFAULT_NAN)
        else $error("signaling NaN not replaced by default NaN");
    end

    if (PIPE_EN) begin : g_chk_pipe
      a_r9_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> out_valid == $past(in_valid))
        else $error("valid not delayed by one cycle");
      a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(in_valid)) |-> $stable(out_word))
        else $error("output word moved without valid input");
    end
  endgenerate

endmodule

// File: tb/tb_nanq_unit.sv
module tb_nanq_unit;

  localparam int NV = 11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;

  logic        n_v, n_q, n_s, n_n;  logic [31:0] n_w;
  logic        i_v, i_q, i_s, i_n;  logic [31:0] i_w;
  logic        o_v, o_q, o_s, o_n;  logic [31:0] o_w;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  nanq_unit #(.QUIET_WHEN_SET(1'b1), .SIGNAL_EN(1'b1), .PIPE_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(n_v), .out_quiet(n_q), .out_signal(n_s), .out_nan(n_n), .out_word(n_w));

  nanq_unit #(.QUIET_WHEN_SET(1'b0), .SIGNAL_EN(1'b1), .PIPE_EN(1'b1)) dut_inv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(i_v), .out_quiet(i_q), .out_signal(i_s), .out_nan(i_n), .out_word(i_w));

  nanq_unit #(.QUIET_WHEN_SET(1'b1), .SIGNAL_EN(1'b0), .PIPE_EN(1'b0)) dut_off (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(o_v), .out_quiet(o_q), .out_signal(o_s), .out_nan(o_n), .out_word(o_w));

  // Stimulus and expected results. Flags are {quiet, signal}.
  localparam logic [31:0] V_IN [NV] = '{
    32'h7F80_0000, 32'hFF80_0000, 32'h0000_0000, 32'h8000_0000, 32'h7F80_0001,
    32'h7FC0_0000, 32'h7FFF_FFFF, 32'hFFBF_FFFF, 32'h3F80_0000, 32'hFFC0_0001,
    32'h007F_FFFF};
  localparam logic [1:0]  N_FL [NV] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b01,
                                        2'b10, 2'b10, 2'b01, 2'b00, 2'b10, 2'b00};
  localparam logic [31:0] N_OUT [NV] = '{
    32'h7F80_0000, 32'hFF80_0000, 32'h0000_0000, 32'h8000_0000, 32'h7FC0_0001,
    32'h7FC0_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h3F80_0000, 32'hFFC0_0001,
    32'h007F_FFFF};
  localparam logic [1:0]  I_FL [NV] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b10,
                                        2'b01, 2'b01, 2'b10, 2'b00, 2'b01, 2'b00};
  localparam logic [31:0] I_OUT [NV] = '{
    32'h7F80_0000, 32'hFF80_0000, 32'h0000_0000, 32'h8000_0000, 32'h7F80_0001,
    32'h7FBF_FFFF, 32'h7FBF_FFFF, 32'hFFBF_FFFF, 32'h3F80_0000, 32'h7FBF_FFFF,
    32'h007F_FFFF};
  localparam logic        O_Q [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
                                       1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string rn;
    string ri;
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0;
    repeat (3) @(negedge clk);
    // R10: reset state of the registered copy
    chk("R10 reset state", {n_v, n_q, n_s, n_n, n_w}, 36'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: {valid, quiet, signal, nan, word}
    for (int k = 0; k < NV; k++) begin
      in_valid = 1'b1;
      in_word  = V_IN[k];
      #1;
      chk("R7 R8 signaling disabled", {o_v, o_q, o_s, o_n, o_w},
          {1'b1, O_Q[k], 1'b0, O_Q[k], V_IN[k]});
      @(negedge clk);
      rn = N_FL[k][0] ? "R2 R4 R8 R9" : (N_FL[k][1] ? "R1 R4 R8 R9" : "R3 R9");
      ri = (I_FL[k] == 2'b00) ? "R3 R9" : "R5 R6 R8 R9";
      chk(rn, {n_v, n_q, n_s, n_n, n_w},
          {1'b1, N_FL[k][1], N_FL[k][0], |N_FL[k], N_OUT[k]});
      chk(ri, {i_v, i_q, i_s, i_n, i_w},
          {1'b1, I_FL[k][1], I_FL[k][0], |I_FL[k], I_OUT[k]});
    end

    // R9: idle cycle holds registered data, drops valid; combinational follows
    in_valid = 1'b0;
    in_word  = 32'h7F80_0001;
    #1;
    chk("R9 comb valid follows", {35'h0, o_v}, 36'h0);
    @(negedge clk);
    chk("R9 hold after idle", {n_v, n_q, n_s, n_n, n_w}, {4'b0000, 32'h007F_FFFF});

    // R9: latency, result not visible before the edge
    in_valid = 1'b1;
    in_word  = 32'h7F80_0001;
    #1;
    chk("R9 no early update", {4'b0000, n_w}, {4'b0000, 32'h007F_FFFF});
    @(negedge clk);
    chk("R9 R4 after one edge", {n_v, n_q, n_s, n_n, n_w}, {4'b1011, 32'h7FC0_0001});

    // R10: asynchronous reset mid-run with valid held high
    rst_n = 1'b0;
    #1;
    chk("R10 reset mid-run", {n_v, i_v, n_q, n_s, n_w}, 36'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 R10 valid after release", {35'h0, n_v}, 36'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule